// File: doc/BRIEF.md
# Comparator Timer Channel

One event channel of a multi-channel timer. The channel watches a shared free-running main counter that steps by one. It compares the counter against a programmable comparator and emits a single-cycle match event. The comparison can run in 64-bit (wide) or 32-bit (narrow) width. In one-shot mode the channel fires each time the counter reaches the comparator. In periodic mode it fires and then moves the comparator forward by a hidden period value.

Software programs the channel through three write strobes: configuration, comparator low word and comparator high word. All three share a data bus. The configuration, comparator and period can be read back on dedicated ports. In periodic mode a comparator write normally programs only the hidden period. A self-clearing set-value bit lets software also load the live comparator. In narrow one-shot mode the channel adds an extra event when the low 32 bits of the counter wrap around. Interrupt routing, bus decoding and the counter itself live in other blocks.

Top module: `tmrch_channel`

## Requirements
- R1: In periodic mode, a write to either comparator half always loads that half of the period register. The live comparator half is loaded only when the set-value bit is 1. In one-shot mode the write loads the comparator and leaves the period alone.
- R2: Any write to either comparator half clears the set-value bit on the following cycle.
- R3: Every value written into the period register has its top bit forced to 0. That is bit 31 in narrow mode and bit 63 in wide mode.
- R4: On a periodic match with a nonzero period, the comparator becomes comparator plus period on the next cycle. The sum is taken modulo 2^32 in narrow mode and modulo 2^64 in wide mode.
- R5: In narrow one-shot mode an armed channel also fires when the low 32 bits of the counter tick to zero. This is in addition to the comparator match. In wide mode a wrap produces no event.
- R6: Writing the configuration with the narrow bit set clears the upper 32 bits of both the comparator and the period. While narrow mode is active, those upper bits read as 0, and high-word writes leave them at 0.
- R7: At reset the comparator reads all ones, the period reads 0 and the configuration reads 0x30. The configuration word layout is:
  - bit 0: channel enable
  - bit 1: periodic
  - bit 2: narrow (32-bit) mode
  - bit 3: set-value
  - bits 4 and 5: read-only ones, advertising periodic and wide capability
  - all other bits: read as 0
- R8: A 0-to-1 write of the enable bit arms the channel only while the global enable is high. A 1-to-0 write disarms the channel. A match in the same cycle as that write produces no event.
- R9: A comparator write while the global enable and the channel enable are both high arms the channel.
- R10: The channel detects a match on a cycle with the tick strobe high, the global enable high and the counter equal to the comparator (in the active width). An armed channel then drives `event_o` high for exactly one cycle after that clock edge.
- R11: With a zero period, periodic mode fires like one-shot and leaves the comparator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | 64 | Main counter value |
| tick_i | input | 1 | Counter stepped to `count_i` this cycle |
| glob_en_i | input | 1 | Global enable |
| cfg_we_i | input | 1 | Configuration write strobe |
| cmp_lo_we_i | input | 1 | Comparator low-word write strobe |
| cmp_hi_we_i | input | 1 | Comparator high-word write strobe |
| wdata_i | input | 32 | Write data for all three strobes |
| event_o | output | 1 | Single-cycle match event |
| cfg_rd_o | output | 32 | Configuration readback |
| cmp_rd_o | output | 64 | Comparator readback |
| per_rd_o | output | 64 | Period readback |

## Verification
The assertions make two assumptions about the inputs. First, each tick advances the counter by exactly one, so equality is enough to detect a match. Second, the configuration strobe and a comparator strobe are never raised in the same cycle. The stimulus follows both rules in all but one place. Every sweep steps the counter one value per tick, and every write task raises a single strobe with the tick held low. The one exception is the deliberate same-cycle disable test. There, a configuration write coincides with a tick at the match value, and the property covering that case still holds.

// File: rtl/tmrch_pkg.sv
package tmrch_pkg;
  localparam int CFG_EN  = 0;
  localparam int CFG_PER = 1;
  localparam int CFG_NAR = 2;
  localparam int CFG_SET = 3;

  typedef struct packed {
    logic setval;
    logic narrow;
    logic periodic;
    logic en;
  } chan_cfg_t;
endpackage

// File: rtl/tmrch_cfg.sv
module tmrch_cfg
  import tmrch_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_we_i,
  input  logic [3:0] cfg_bits_i,
  input  logic      cmp_we_i,
  input  logic      glob_en_i,
  output chan_cfg_t cfg_o,
  output logic      armed_o
);
  chan_cfg_t cfg_q, cfg_d;
  logic      armed_q, armed_d;

  always_comb begin
    cfg_d   = cfg_q;
    armed_d = armed_q;
    if (cfg_we_i) begin
      cfg_d.en       = cfg_bits_i[CFG_EN];
      cfg_d.periodic = cfg_bits_i[CFG_PER];
      cfg_d.narrow   = cfg_bits_i[CFG_NAR];
      cfg_d.setval   = cfg_bits_i[CFG_SET];
      if (!cfg_q.en && cfg_bits_i[CFG_EN] && glob_en_i)
        armed_d = 1'b1;
      else if (cfg_q.en && !cfg_bits_i[CFG_EN])
        armed_d = 1'b0;
    end
    if (cmp_we_i) begin
      cfg_d.setval = 1'b0;
      if (glob_en_i && cfg_d.en)
        armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      armed_q <= armed_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign armed_o = armed_q;

  // R2: set-value self-clears after a comparator write
  a_r2_setval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_we_i |=> !cfg_q.setval);

  // R8: an armed channel always has its enable bit set
  a_r8_armed_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> cfg_q.en);
endmodule

// File: rtl/tmrch_cmp.sv
module tmrch_cmp
  import tmrch_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  chan_cfg_t           cfg_i,
  input  logic                lo_we_i,
  input  logic                hi_we_i,
  input  logic [HALF_W-1:0]   wdata_i,
  input  logic                trunc_i,
  input  logic                adv_i,
  output logic [2*HALF_W-1:0] cmp_o,
  output logic [2*HALF_W-1:0] per_o
);
  localparam int CNT_W = 2 * HALF_W;

  logic [CNT_W-1:0]  cmp_q, cmp_d, per_q, per_d;
  logic [CNT_W-1:0]  sum_wide;
  logic [HALF_W-1:0] sum_narrow;
  logic [HALF_W-1:0] per_lo_val, per_hi_val;
  logic              load_cmp;

  assign sum_wide   = cmp_q + per_q;
  assign sum_narrow = cmp_q[HALF_W-1:0] + per_q[HALF_W-1:0];
  assign load_cmp   = !cfg_i.periodic || cfg_i.setval;
  assign per_lo_val = cfg_i.narrow ? {1'b0, wdata_i[HALF_W-2:0]} : wdata_i;
  assign per_hi_val = {1'b0, wdata_i[HALF_W-2:0]};

  always_comb begin
    cmp_d = cmp_q;
    per_d = per_q;
    if (adv_i)
      cmp_d = cfg_i.narrow ? {{HALF_W{1'b0}}, sum_narrow} : sum_wide;
    if (lo_we_i) begin
      if (load_cmp)       cmp_d[HALF_W-1:0] = wdata_i;
      if (cfg_i.periodic) per_d[HALF_W-1:0] = per_lo_val;
    end
    if (hi_we_i && !cfg_i.narrow) begin
      if (load_cmp)       cmp_d[CNT_W-1:HALF_W] = wdata_i;
      if (cfg_i.periodic) per_d[CNT_W-1:HALF_W] = per_hi_val;
    end
    if (trunc_i) begin
      cmp_d[CNT_W-1:HALF_W] = '0;
      per_d[CNT_W-1:HALF_W] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;

  // R1: periodic write without set-value leaves the live comparator alone
  a_r1_cmp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_we_i && cfg_i.periodic && !cfg_i.setval && !trunc_i) |=> cmp_q == $past(cmp_q));

  // R3: the wide period top bit never becomes set
  a_r3_per_msb: assert property (@(posedge clk) disable iff (!rst_n)
    !per_q[CNT_W-1]);

  // R6: narrow mode keeps both upper halves at zero
  a_r6_narrow_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.narrow |-> (cmp_q[CNT_W-1:HALF_W] == '0 && per_q[CNT_W-1:HALF_W] == '0));
endmodule

// File: rtl/tmrch_match.sv
module tmrch_match
  import tmrch_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic [2*HALF_W-1:0] count_i,
  input  logic                tick_i,
  input  logic                glob_en_i,
  input  logic                armed_i,
  input  logic                kill_i,
  input  logic                cmp_we_i,
  input  chan_cfg_t           cfg_i,
  input  logic [2*HALF_W-1:0] cmp_i,
  input  logic [2*HALF_W-1:0] per_i,
  output logic                fire_o,
  output logic                adv_o
);
  logic live, eq, wrap_hit;

  assign live     = armed_i && glob_en_i && tick_i && !kill_i;
  assign eq       = cfg_i.narrow ? (count_i[HALF_W-1:0] == cmp_i[HALF_W-1:0])
                                 : (count_i == cmp_i);
  assign wrap_hit = cfg_i.narrow && !cfg_i.periodic && (count_i[HALF_W-1:0] == '0);
  assign fire_o   = live && (eq || wrap_hit);
  assign adv_o    = live && eq && cfg_i.periodic && (per_i != '0) && !cmp_we_i;
endmodule

// File: rtl/tmrch_channel.sv
module tmrch_channel
  import tmrch_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*HALF_W-1:0] count_i,
  input  logic                tick_i,
  input  logic                glob_en_i,
  input  logic                cfg_we_i,
  input  logic                cmp_lo_we_i,
  input  logic                cmp_hi_we_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic                event_o,
  output logic [HALF_W-1:0]   cfg_rd_o,
  output logic [2*HALF_W-1:0] cmp_rd_o,
  output logic [2*HALF_W-1:0] per_rd_o
);
  localparam int CNT_W = 2 * HALF_W;

  chan_cfg_t        cfg;
  logic             armed, fire, adv, cmp_we, kill, trunc;
  logic [CNT_W-1:0] cmp_v, per_v;
  logic             event_q, event_d;
  logic             unused_wdata;

  assign cmp_we       = cmp_lo_we_i || cmp_hi_we_i;
  assign kill         = cfg_we_i && !wdata_i[CFG_EN];
  assign trunc        = cfg_we_i && wdata_i[CFG_NAR];
  assign unused_wdata = ^wdata_i[HALF_W-1:4];

  tmrch_cfg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we_i   (cfg_we_i),
    .cfg_bits_i (wdata_i[3:0]),
    .cmp_we_i   (cmp_we),
    .glob_en_i  (glob_en_i),
    .cfg_o      (cfg),
    .armed_o    (armed)
  );

  tmrch_cmp #(.HALF_W(HALF_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_i   (cfg),
    .lo_we_i (cmp_lo_we_i),
    .hi_we_i (cmp_hi_we_i),
    .wdata_i (wdata_i),
    .trunc_i (trunc),
    .adv_i   (adv),
    .cmp_o   (cmp_v),
    .per_o   (per_v)
  );

  tmrch_match #(.HALF_W(HALF_W)) u_match (
    .count_i   (count_i),
    .tick_i    (tick_i),
    .glob_en_i (glob_en_i),
    .armed_i   (armed),
    .kill_i    (kill),
    .cmp_we_i  (cmp_we),
    .cfg_i     (cfg),
    .cmp_i     (cmp_v),
    .per_i     (per_v),
    .fire_o    (fire),
    .adv_o     (adv)
  );

  assign event_d = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) event_q <= 1'b0;
    else        event_q <= event_d;
  end

  assign event_o  = event_q;
  assign cfg_rd_o = {{(HALF_W-6){1'b0}}, 2'b11, cfg.setval, cfg.narrow, cfg.periodic, cfg.en};
  assign cmp_rd_o = cmp_v;
  assign per_rd_o = per_v;

  // R10: every event follows a tick in the previous cycle
  a_r10_event_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(tick_i));

  // R8: a disabling configuration write suppresses the event
  a_r8_kill_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !wdata_i[CFG_EN]) |=> !event_o);

  // R10: an event needs the global enable on the tick
  a_r10_event_needs_glob: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(glob_en_i));
endmodule

// File: tb/tmrch_channel_test.sv
module tmrch_channel_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] EN = 32'h1, PER = 32'h2, NAR = 32'h4, SET = 32'h8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] count;
  logic        tick, glob, cfg_we, lo_we, hi_we;
  logic [31:0] wdata;
  logic        event_o;
  logic [31:0] cfg_rd;
  logic [63:0] cmp_rd, per_rd;

  int errors = 0;
  int checks = 0;
  int nev;
  logic [63:0] ev_at;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmrch_channel uut (
    .clk(clk), .rst_n(rst_n), .count_i(count), .tick_i(tick), .glob_en_i(glob),
    .cfg_we_i(cfg_we), .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we), .wdata_i(wdata),
    .event_o(event_o), .cfg_rd_o(cfg_rd), .cmp_rd_o(cmp_rd), .per_rd_o(per_rd)
  );

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic tk(input logic [63:0] v);
    @(negedge clk);
    count = v; tick = 1'b1;
    @(posedge clk); #1;
    tick = 1'b0;
    if (event_o) begin nev++; ev_at = v; end
  endtask

  task automatic run(input logic [63:0] lo, input logic [63:0] hi);
    for (logic [63:0] v = lo; v <= hi; v++) tk(v);
  endtask

  task automatic wcfg(input logic [31:0] d);
    @(negedge clk); cfg_we = 1'b1; wdata = d;
    @(posedge clk); #1; cfg_we = 1'b0;
  endtask

  task automatic wlo(input logic [31:0] d);
    @(negedge clk); lo_we = 1'b1; wdata = d;
    @(posedge clk); #1; lo_we = 1'b0;
  endtask

  task automatic whi(input logic [31:0] d);
    @(negedge clk); hi_we = 1'b1; wdata = d;
    @(posedge clk); #1; hi_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; count = '0; tick = 0; glob = 1; cfg_we = 0; lo_we = 0; hi_we = 0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk("R7 cfg reset", {32'h0, cfg_rd}, 64'h30);
    chk("R7 cmp reset", cmp_rd, '1);
    chk("R7 per reset", per_rd, 64'h0);
    chk("R7 event reset", {63'h0, event_o}, 64'h0);

    // R10: one-shot wide sweep over comparator values
    for (int n = 3; n <= 10; n++) begin
      wcfg(0); whi(0); wlo(n); wcfg(EN);
      nev = 0; ev_at = '1;
      run(0, 15);
      chk("R10 one-shot count", nev, 1);
      chk("R10 one-shot position", ev_at, n);
    end

    // R4/R11/R1/R2: periodic sweep over periods
    for (int p = 0; p <= 4; p++) begin
      logic [63:0] c;
      int expn;
      wcfg(0); wcfg(PER | SET); whi(0);
      wcfg(PER | SET); wlo(2);
      chk("R2 setval cleared", {32'h0, cfg_rd}, 64'h32);
      chk("R1 period loaded with setval", per_rd, 64'h2);
      wlo(p);
      chk("R1 cmp held without setval", cmp_rd, 64'h2);
      chk("R1 period loaded", per_rd, p);
      wcfg(EN | PER);
      nev = 0; c = 2; expn = 0;
      for (int v = 0; v <= 20; v++) if (v == c) begin expn++; if (p != 0) c = c + p; end
      run(0, 20);
      chk(p == 0 ? "R11 zero period count" : "R4 periodic count", nev, expn);
      chk(p == 0 ? "R11 zero period cmp" : "R4 advanced cmp", cmp_rd, c);
    end

    // R8: enabling while global enable is low does not arm
    wcfg(0); whi(0); glob = 0; wlo(5); wcfg(EN); glob = 1;
    nev = 0; run(0, 10);
    chk("R8 no arm without global", nev, 0);
    // R9: comparator write arms
    wlo(5);
    nev = 0; run(0, 10);
    chk("R9 write arms", nev, 1);

    // R8: disable withdraws
    wcfg(0); wlo(6); wcfg(EN);
    nev = 0; run(0, 3); wcfg(0); run(4, 10);
    chk("R8 disarm", nev, 0);
    wcfg(EN);
    @(negedge clk); count = 6; tick = 1; cfg_we = 1; wdata = 0;
    @(posedge clk); #1; tick = 0; cfg_we = 0;
    chk("R8 same-cycle kill", {63'h0, event_o}, 64'h0);

    // R5: narrow one-shot wrap event versus wide
    wcfg(0); whi(0); wlo(16); wcfg(NAR); wcfg(NAR | EN);
    begin
      int expn = 0;
      for (logic [63:0] v = 64'hFFFF_FFF0; v <= 64'h1_0000_0014; v++)
        if (v[31:0] == 32'h10 || v[31:0] == 32'h0) expn++;
      nev = 0; run(64'hFFFF_FFF0, 64'h1_0000_0014);
      chk("R5 narrow wrap events", nev, expn);
    end
    wcfg(0); wcfg(EN);
    nev = 0; run(64'hFFFF_FFF0, 64'h1_0000_0014);
    chk("R5 wide no wrap event", nev, 0);

    // R6: narrow selection truncates
    wcfg(0); whi(1); wlo(5);
    wcfg(PER); whi(3); wlo(7);
    chk("R1 cmp unchanged periodic", cmp_rd, 64'h1_0000_0005);
    chk("R1 per both halves", per_rd, 64'h3_0000_0007);
    wcfg(NAR);
    chk("R6 cmp truncated", cmp_rd, 64'h5);
    chk("R6 per truncated", per_rd, 64'h7);
    whi(32'hABC);
    chk("R6 high write ignored narrow", cmp_rd, 64'h5);

    // R3: period MSB forced
    wcfg(PER); whi(32'hFFFF_FFFF);
    chk("R3 wide msb", per_rd, 64'h7FFF_FFFF_0000_0007);
    wcfg(PER | NAR); wlo(32'hFFFF_FFFF);
    chk("R3 narrow msb", per_rd, 64'h7FFF_FFFF);

    // R4: narrow periodic advance across wrap
    wcfg(NAR | PER | SET); wlo(32'hFFFF_FFFE); wlo(4);
    wcfg(NAR | PER | EN);
    nev = 0; run(64'hFFFF_FFF0, 64'h1_0000_0000);
    chk("R4 narrow match count", nev, 1);
    chk("R4 narrow wrap sum", cmp_rd, 64'h2);
    nev = 0; run(64'h1_0000_0001, 64'h1_0000_0004);
    chk("R4 narrow second match", nev, 1);
    chk("R4 narrow cmp after", cmp_rd, 64'h6);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule